// File: doc/BRIEF.md
# First-Error Capture Status Register

This block records faults reported by a bridge that joins two internal buses, a north side and a south side. Each fault report carries the ID of the requester that issued the failing transaction, whether that transaction was a read or a write, and a 2-bit error class. The side the report arrives on is recorded as well. Only the earliest fault is kept. Any fault that arrives while a record is held raises a separate overflow flag and leaves the captured details alone.

Software reaches the block through a single-cycle 32-bit register port. Reading the register returns its current image and clears the two flag bits at the same clock edge. Writing the register changes only the reporting-enable bit. While that enable is set, the level interrupt output follows the flags and stays high until a read clears them.

Top module: `errlog_status_reg`

## Requirements
- R1: After a synchronous active-low reset, every register bit is zero and `irq` is low.
- R2: A fault seen while bit 0 is clear sets bit 0 at the next edge and captures its details: the requester ID in bits 11:8, the side in bit 5 (0 north, 1 south), the command in bit 4 (0 read, 1 write) and the error class in bits 3:2.
- R3: A fault seen while bit 0 is set sets bit 1 and leaves bits 11:8 and 5:2 unchanged.
- R4: A read (`reg_sel`=1, `reg_wr`=0) returns the pre-edge image and clears bits 1:0 at that edge, while the captured fields stay as they were.
- R5: When a fault coincides with a clearing read, the read returns the old image, and after the edge the fault is held as a first fault: bit 0 is 1, bit 1 is 0, and the fields are new.
- R6: When both sides report in one cycle and bit 0 is clear, the north report is captured and bits 0 and 1 are both set.
- R7: A write (`reg_sel`=1, `reg_wr`=1) loads bit 16 from `reg_wdata[16]` and changes no other bit.
- R8: Bits 31:17, 15:12 and 7:6 always read as zero.
- R9: `irq` is high exactly when bit 16 is set and bit 0 or bit 1 is set. It stays high until a read clears the flags.
- R10: With bit 16 clear, faults are still logged, but `irq` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| north_err | input | 1 | Fault report strobe from the north side |
| north_req_id | input | 4 | Requester ID of the north fault |
| north_cmd_wr | input | 1 | North fault command: 1 write, 0 read |
| north_etype | input | 2 | North fault error class |
| south_err | input | 1 | Fault report strobe from the south side |
| south_req_id | input | 4 | Requester ID of the south fault |
| south_cmd_wr | input | 1 | South fault command: 1 write, 0 read |
| south_etype | input | 2 | South fault error class |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 for write, 0 for read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Register image, valid while `reg_sel` is high |
| irq | output | 1 | Level interrupt |

## Verification
The delicate overlap is a clearing read that lands in the same cycle as a new fault. The clear and the capture then act on one edge. The bench drives a read together with a south fault while an older record is held. It checks that the read data shows the old image with the flags cleared by the prior read. A following read must then show the new fields, bit 0 set and bit 1 clear. Two more overlaps get the same treatment: simultaneous north and south reports, and a write that arrives while a record is held.

// File: rtl/errlog_pkg.sv
// Package: errlog_pkg
// Shared widths, register bit positions and record types for the
// first-error capture register. Assumes a 32-bit register image.
package errlog_pkg;
    localparam int REG_W     = 32;
    localparam int REQ_W     = 4;
    localparam int ETYPE_W   = 2;

    // Bit positions that software decodes
    localparam int FIRST_BIT = 0;
    localparam int MULTI_BIT = 1;
    localparam int ETYPE_LSB = 2;
    localparam int CMD_BIT   = 4;
    localparam int SIDE_BIT  = 5;
    localparam int REQ_LSB   = 8;
    localparam int EN_BIT    = 16;

    // Details carried by one fault report
    typedef struct packed {
        logic [REQ_W-1:0]   req_id;
        logic               cmd_wr;
        logic [ETYPE_W-1:0] etype;
    } err_info_t;

    // Captured record: report details plus the side it came from
    typedef struct packed {
        err_info_t info;
        logic      south;
    } err_rec_t;
endpackage

// File: rtl/errlog_select.sv
// Module: errlog_select
// Merges the two side report ports into one candidate record per cycle.
// North wins when both sides report together; `both` tells the recorder
// that a second fault was seen in the same cycle. Purely combinational.
module errlog_select
    import errlog_pkg::*;
(
    input  logic      n_valid,
    input  err_info_t n_info,
    input  logic      s_valid,
    input  err_info_t s_info,
    output logic      any,
    output logic      both,
    output err_rec_t  win
);
    // Pick the winning report and flag coincident reports
    always_comb begin
        any  = n_valid | s_valid;
        both = n_valid & s_valid;
        if (n_valid) begin
            win.info  = n_info;
            win.south = 1'b0;
        end else begin
            win.info  = s_info;
            win.south = 1'b1;
        end
    end
endmodule

// File: rtl/errlog_record.sv
// Module: errlog_record
// Holds the first-fault flag, the overflow flag and the captured record.
// Assumes rd_clr is a one-cycle pulse that clears the flags at the edge.
// A fault on that edge is judged against the cleared flags.
module errlog_record
    import errlog_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     err_any,
    input  logic     err_both,
    input  err_rec_t err_win,
    input  logic     rd_clr,
    output logic     first_q,
    output logic     multi_q,
    output err_rec_t rec_q
);
    logic first_base;
    logic multi_base;

    // Flag values after any clear requested this cycle
    always_comb begin
        first_base = rd_clr ? 1'b0 : first_q;
        multi_base = rd_clr ? 1'b0 : multi_q;
    end

    // Capture the first fault, flag later ones, apply read clears
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q <= 1'b0;
            multi_q <= 1'b0;
            rec_q   <= '0;
        end else if (err_any && !first_base) begin
            first_q <= 1'b1;
            multi_q <= err_both;
            rec_q   <= err_win;
        end else if (err_any) begin
            first_q <= first_base;
            multi_q <= 1'b1;
        end else begin
            first_q <= first_base;
            multi_q <= multi_base;
        end
    end

    assert_first_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (err_any && !first_q) |=> (first_q && rec_q == $past(err_win)));

    assert_hold_fields_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (err_any && first_q && !rd_clr) |=> (multi_q && $stable(rec_q)));

    assert_clear_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !err_any) |=> (!first_q && !multi_q && $stable(rec_q)));

    assert_clear_then_log_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && err_any && !err_both) |=> (first_q && !multi_q));

    assert_north_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (err_both && !first_q) |=> (first_q && multi_q && !rec_q.south));
endmodule

// File: rtl/errlog_regif.sv
// Module: errlog_regif
// Register port: assembles the read image, turns a read into a clear
// pulse, holds the reporting enable and drives the level interrupt.
// Assumes one access per cycle; reg_wr chooses write over read.
module errlog_regif
    import errlog_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    input  logic             err_any,
    input  logic             first_q,
    input  logic             multi_q,
    input  err_rec_t         rec_q,
    output logic [REG_W-1:0] rdata,
    output logic             rd_clr,
    output logic             irq
);
    logic en_q;
    logic unused_wdata;

    assign unused_wdata = ^{wdata[REG_W-1:EN_BIT+1], wdata[EN_BIT-1:0]};

    // Read strobe becomes the flag clear pulse
    always_comb rd_clr = sel & ~wr;

    // Build the read image; reserved bits stay zero
    always_comb begin
        rdata = '0;
        rdata[EN_BIT]                        = en_q;
        rdata[REQ_LSB +: REQ_W]              = rec_q.info.req_id;
        rdata[SIDE_BIT]                      = rec_q.south;
        rdata[CMD_BIT]                       = rec_q.info.cmd_wr;
        rdata[ETYPE_LSB +: ETYPE_W]          = rec_q.info.etype;
        rdata[MULTI_BIT]                     = multi_q;
        rdata[FIRST_BIT]                     = first_q;
    end

    // Reporting enable updates only on writes
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else if (sel && wr) en_q <= wdata[EN_BIT];
    end

    // Level interrupt from enable and flags
    always_comb irq = en_q & (first_q | multi_q);

    assert_write_keeps_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr && !err_any) |=> ($stable(first_q) && $stable(multi_q) && $stable(rec_q)));

    assert_irq_drops_after_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !err_any) |=> !irq);

    assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && wr && !wdata[EN_BIT]) |=> !irq);
endmodule

// File: rtl/errlog_status_reg.sv
// Module: errlog_status_reg
// Top of the first-error capture register. Wires the side merger, the
// record keeper and the register port together. Assumes the report
// strobes are single-cycle and synchronous to clk.
module errlog_status_reg
    import errlog_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               north_err,
    input  logic [REQ_W-1:0]   north_req_id,
    input  logic               north_cmd_wr,
    input  logic [ETYPE_W-1:0] north_etype,
    input  logic               south_err,
    input  logic [REQ_W-1:0]   south_req_id,
    input  logic               south_cmd_wr,
    input  logic [ETYPE_W-1:0] south_etype,
    input  logic               reg_sel,
    input  logic               reg_wr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    output logic               irq
);
    err_info_t n_info;
    err_info_t s_info;
    err_rec_t  win;
    err_rec_t  rec_q;
    logic      any;
    logic      both;
    logic      rd_clr;
    logic      first_q;
    logic      multi_q;

    // Pack side report fields
    always_comb begin
        n_info = '{req_id: north_req_id, cmd_wr: north_cmd_wr, etype: north_etype};
        s_info = '{req_id: south_req_id, cmd_wr: south_cmd_wr, etype: south_etype};
    end

    errlog_select u_select (
        .n_valid (north_err),
        .n_info  (n_info),
        .s_valid (south_err),
        .s_info  (s_info),
        .any     (any),
        .both    (both),
        .win     (win)
    );

    errlog_record u_record (
        .clk      (clk),
        .rst_n    (rst_n),
        .err_any  (any),
        .err_both (both),
        .err_win  (win),
        .rd_clr   (rd_clr),
        .first_q  (first_q),
        .multi_q  (multi_q),
        .rec_q    (rec_q)
    );

    errlog_regif u_regif (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (reg_sel),
        .wr      (reg_wr),
        .wdata   (reg_wdata),
        .err_any (any),
        .first_q (first_q),
        .multi_q (multi_q),
        .rec_q   (rec_q),
        .rdata   (reg_rdata),
        .rd_clr  (rd_clr),
        .irq     (irq)
    );
endmodule

// File: tb/errlog_status_reg_bench.sv
module errlog_status_reg_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        north_err = 0, south_err = 0;
    logic [3:0]  north_req_id = 0, south_req_id = 0;
    logic        north_cmd_wr = 0, south_cmd_wr = 0;
    logic [1:0]  north_etype = 0, south_etype = 0;
    logic        reg_sel = 0, reg_wr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic        irq;
    int          checks = 0;
    int          errors = 0;
    bit          done = 0;

    always #5 clk = ~clk;

    errlog_status_reg u_errlog_status_reg (.*);

    // report packing: {req_id[3:0], cmd_wr, etype[1:0]}
    typedef struct packed {
        logic        rd;
        logic        wr;
        logic        n;
        logic        s;
        logic [6:0]  nrep;
        logic [6:0]  srep;
        logic [31:0] wdata;
        logic [31:0] exp;
        logic        exp_irq;
        logic [3:0]  tag;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t TBL [NV] = '{
        '{1,0,0,0,7'h00,7'h00,32'h0,       32'h0,      1'b0,4'd1},  // R1 reset image
        '{0,0,1,0,7'h1E,7'h00,32'h0,       32'h0,      1'b0,4'd2},  // R2 north fault
        '{1,0,0,0,7'h00,7'h00,32'h0,       32'h319,    1'b0,4'd2},  // R2 R10 captured, masked
        '{1,0,0,0,7'h00,7'h00,32'h0,       32'h318,    1'b0,4'd4},  // R4 flags cleared
        '{0,1,0,0,7'h00,7'h00,32'hFFFFFFFF,32'h0,      1'b0,4'd7},  // R7 enable
        '{1,0,0,0,7'h00,7'h00,32'h0,       32'h10318,  1'b0,4'd8},  // R8 R7 reserved zero
        '{0,0,0,1,7'h00,7'h49,32'h0,       32'h0,      1'b0,4'd2},  // R2 south fault
        '{0,0,0,0,7'h00,7'h00,32'h0,       32'h0,      1'b1,4'd9},  // R9 irq high
        '{0,0,1,0,7'h2F,7'h00,32'h0,       32'h0,      1'b1,4'd3},  // R3 second fault
        '{1,0,0,0,7'h00,7'h00,32'h0,       32'h10927,  1'b1,4'd3},  // R3 fields kept
        '{0,0,0,0,7'h00,7'h00,32'h0,       32'h0,      1'b0,4'd4},  // R4 R9 irq cleared
        '{1,0,0,1,7'h00,7'h14,32'h0,       32'h10924,  1'b0,4'd5},  // R5 read + fault
        '{1,0,0,0,7'h00,7'h00,32'h0,       32'h10231,  1'b1,4'd5},  // R5 new first
        '{0,0,1,1,7'h0A,7'h25,32'h0,       32'h0,      1'b0,4'd6},  // R6 both sides
        '{1,0,0,0,7'h00,7'h00,32'h0,       32'h1010B,  1'b1,4'd6},  // R6 north wins
        '{0,1,0,0,7'h00,7'h00,32'h0,       32'h0,      1'b0,4'd7},  // R7 disable
        '{0,0,1,0,7'h7F,7'h00,32'h0,       32'h0,      1'b0,4'd10}, // R10 fault
        '{0,0,0,0,7'h00,7'h00,32'h0,       32'h0,      1'b0,4'd10}, // R10 masked
        '{0,1,0,0,7'h00,7'h00,32'h10000,   32'h0,      1'b0,4'd7},  // R7 enable only
        '{0,0,0,0,7'h00,7'h00,32'h0,       32'h0,      1'b1,4'd9},  // R9 level
        '{0,1,0,0,7'h00,7'h00,32'hFFFEFFFF,32'h0,      1'b1,4'd7},  // R7 ones elsewhere
        '{1,0,0,0,7'h00,7'h00,32'h0,       32'hF1D,    1'b0,4'd7},  // R7 fields unchanged
        '{1,0,0,0,7'h00,7'h00,32'h0,       32'hF1C,    1'b0,4'd4}   // R4 cleared
    };

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic rd, input logic wr, input logic n, input logic s,
                         input logic [6:0] nrep, input logic [6:0] srep, input logic [31:0] wd);
        @(negedge clk);
        reg_sel = rd | wr;
        reg_wr = wr;
        reg_wdata = wd;
        north_err = n;
        {north_req_id, north_cmd_wr, north_etype} = nrep;
        south_err = s;
        {south_req_id, south_cmd_wr, south_etype} = srep;
        #2;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            drive(TBL[i].rd, TBL[i].wr, TBL[i].n, TBL[i].s, TBL[i].nrep, TBL[i].srep, TBL[i].wdata);
            if (TBL[i].rd)
                check(reg_rdata == TBL[i].exp, $sformatf("R%0d rdata step %0d", TBL[i].tag, i),
                      reg_rdata, TBL[i].exp);
            check(irq == TBL[i].exp_irq, $sformatf("R%0d irq step %0d", TBL[i].tag, i),
                  {31'b0, irq}, {31'b0, TBL[i].exp_irq});
        end
        // R3 R6: both sides while a record is held
        drive(0,0,1,0,7'h3B,7'h00,32'h0);
        drive(0,0,1,1,7'h11,7'h66,32'h0);
        drive(1,0,0,0,7'h00,7'h00,32'h0);
        check(reg_rdata == 32'h70F, "R3 both sides after first", reg_rdata, 32'h70F);
        // R1: reset in mid-run wipes record and enable
        drive(0,1,0,1,7'h00,7'h55,32'h10000);
        drive(0,0,0,0,7'h00,7'h00,32'h0);
        check(irq == 1'b1, "R9 before reset", {31'b0, irq}, 32'h1);
        rst_n = 1'b0;
        drive(0,0,0,0,7'h00,7'h00,32'h0);
        drive(0,0,0,0,7'h00,7'h00,32'h0);
        rst_n = 1'b1;
        check(irq == 1'b0, "R1 irq after reset", {31'b0, irq}, 32'h0);
        drive(1,0,0,0,7'h00,7'h00,32'h0);
        check(reg_rdata == 32'h0, "R1 image after reset", reg_rdata, 32'h0);
        drive(0,0,0,0,7'h00,7'h00,32'h0);
        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end
endmodule